// File: doc/BRIEF.md
# Wrapping Big-Endian Byte Scratchpad

This block is a 4 KiB on-chip data scratchpad. A client reaches it through one synchronous port. Each access reads or writes a single byte, a 16-bit halfword or a 32-bit word. Multi-byte values are held most-significant byte first, so the byte at the lowest address carries the top bits of the value.

Addresses are byte addresses and carry no alignment constraint. Every byte of an access computes its own address modulo the memory size. A halfword or word that begins in the last bytes of the space therefore continues at byte zero instead of faulting or spilling.

Read data is registered and appears one clock after the request. It then holds until the next read. Narrow reads are zero-extended to 32 bits.

Top module: `spm_scratchpad`

## Requirements
- R1: The memory holds 4096 independently addressable bytes. Writing one byte address never changes any other byte address.
- R2: A halfword read at byte address A returns byte A in bits 15:8 and byte A+1 in bits 7:0.
- R3: A word read at A returns bytes A, A+1, A+2 and A+3, from bits 31:24 down to bits 7:0. There is no alignment restriction on A.
- R4: Each byte address of an access is reduced modulo 4096 on its own. A word at 0xFFE uses bytes 0xFFE, 0xFFF, 0x000 and 0x001, and a halfword at 0xFFF uses bytes 0xFFF and 0x000.
- R5: Writes use the same byte order as reads. A byte write stores wdata[7:0] at A. A halfword write stores wdata[15:8] at A and wdata[7:0] at A+1. A word write stores wdata[31:24] at A through wdata[7:0] at A+3. Bytes outside the access are left unchanged.
- R6: The read data for a request presented at a clock edge is on acc_rdata after that edge. Back-to-back reads each deliver their data one cycle later.
- R7: acc_size selects the access size: 0 is byte, 1 is halfword, 2 is word, and 3 behaves as word. Byte reads return zeros in bits 31:8, and halfword reads return zeros in bits 31:16.
- R8: acc_rdata keeps its value in any cycle without a read request. This includes idle cycles and writes, even a write to the address that was last read.
- R9: A write followed in the next cycle by a read of the same size and address returns the written value, masked to the access size.
- R10: Reset sets acc_rdata to zero. Reset does not alter the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read-data path |
| acc_en | input | 1 | Access request in this cycle |
| acc_we | input | 1 | 1 = write, 0 = read (qualified by acc_en) |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| acc_addr | input | 12 | Byte address of the first (most significant) byte |
| acc_wdata | input | 32 | Write value, right-justified for byte and halfword |
| acc_rdata | output | 32 | Registered read value, zero-extended |

## Verification
The hardest case to provoke is an access whose bytes straddle the top of the space. It must land in the right byte lanes of the right rows on both sides of the wrap, and it must not disturb its neighbours. The bench first fills every byte with a distinct pattern. It then reads halfwords and words at every one of the 4096 start addresses, so each starting offset within a lane group and each wrap point is visited. After that it applies pseudo-random misaligned writes of all sizes, each read back in the very next cycle, and checks the bytes around each write.

// File: rtl/spm_pkg.sv
package spm_pkg;

    // Access size codes seen on the port
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3   // alias of word
    } spm_size_e;

endpackage

// File: rtl/spm_bank.sv
// One byte-wide bank: synchronous write, registered read that holds when idle.
module spm_bank #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] row,
    input  logic [7:0]       wr_byte,
    output logic [7:0]       rd_byte
);
    localparam int ROWS = 1 << ROW_W;

    logic [7:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[row] <= wr_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_byte <= '0;
        end else if (rd_en) begin
            rd_byte <= cells[row];
        end
    end

endmodule

// File: rtl/spm_lane_route.sv
// Maps one access onto the byte banks: each bank learns which byte of the
// access (if any) falls on it, at which row, and which write byte it takes.
module spm_lane_route
    import spm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                                  en,
    input  logic                                  we,
    input  spm_size_e                             size,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [DATA_W-1:0]                     wdata,
    output logic [DATA_W/8-1:0][ADDR_W-$clog2(DATA_W/8)-1:0] bank_row,
    output logic [DATA_W/8-1:0]                   bank_we,
    output logic                                  bank_re,
    output logic [DATA_W/8-1:0][7:0]              bank_wbyte
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic [OFS_W:0] nbytes;

    always_comb begin
        unique case (size)
            SZ_BYTE: nbytes = (OFS_W+1)'(1);
            SZ_HALF: nbytes = (OFS_W+1)'(2);
            default: nbytes = (OFS_W+1)'(LANES);
        endcase
    end

    assign bank_re = en && !we;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [OFS_W-1:0]  lane;     // position of this bank's byte within the access
        logic [ADDR_W-1:0] baddr;    // wrapped byte address landing on this bank
        logic [OFS_W:0]    idx;      // byte index counted from the value's LSB
        logic [DATA_W-1:0] shifted;

        assign lane          = OFS_W'(b) - addr[OFS_W-1:0];
        assign baddr         = addr + ADDR_W'(lane);
        assign bank_row[b]   = baddr[ADDR_W-1:OFS_W];
        assign idx           = nbytes - (OFS_W+1)'(1) - {1'b0, lane};
        assign shifted       = wdata >> {idx, 3'b000};
        assign bank_wbyte[b] = shifted[7:0];
        assign bank_we[b]    = en && we && ({1'b0, lane} < nbytes);
    end

endmodule

// File: rtl/spm_read_merge.sv
// Remembers the offset and size of the last read and rebuilds the
// big-endian, zero-extended value from the bank outputs.
module spm_read_merge
    import spm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  logic [$clog2(DATA_W/8)-1:0]       addr_lo,
    input  spm_size_e                         size,
    input  logic [DATA_W/8-1:0][7:0]          bank_rbyte,
    output logic [DATA_W-1:0]                 rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);

    logic [OFS_W-1:0] off_q;
    logic [OFS_W:0]   n_q;
    logic [OFS_W-1:0] src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
            n_q   <= (OFS_W+1)'(1);
        end else if (rd_en) begin
            off_q <= addr_lo;
            unique case (size)
                SZ_BYTE: n_q <= (OFS_W+1)'(1);
                SZ_HALF: n_q <= (OFS_W+1)'(2);
                default: n_q <= (OFS_W+1)'(LANES);
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        src   = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(n_q)) begin
                src = off_q + OFS_W'(k);
                rdata[(int'(n_q) - 1 - k) * 8 +: 8] = bank_rbyte[src];
            end
        end
    end

endmodule

// File: rtl/spm_scratchpad.sv
module spm_scratchpad
    import spm_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [1:0]        acc_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = $clog2(LANES);
    localparam int ROW_W = ADDR_W - OFS_W;

    spm_size_e                    size_e;
    logic [LANES-1:0][ROW_W-1:0]  bank_row;
    logic [LANES-1:0]             bank_we;
    logic                         bank_re;
    logic [LANES-1:0][7:0]        bank_wbyte;
    logic [LANES-1:0][7:0]        bank_rbyte;

    assign size_e = spm_size_e'(acc_size);

    spm_lane_route #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_route (
        .en         (acc_en),
        .we         (acc_we),
        .size       (size_e),
        .addr       (acc_addr),
        .wdata      (acc_wdata),
        .bank_row   (bank_row),
        .bank_we    (bank_we),
        .bank_re    (bank_re),
        .bank_wbyte (bank_wbyte)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        spm_bank #(
            .ROW_W (ROW_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_we[b]),
            .rd_en   (bank_re),
            .row     (bank_row[b]),
            .wr_byte (bank_wbyte[b]),
            .rd_byte (bank_rbyte[b])
        );
    end

    spm_read_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (bank_re),
        .addr_lo    (acc_addr[OFS_W-1:0]),
        .size       (size_e),
        .bank_rbyte (bank_rbyte),
        .rdata      (acc_rdata)
    );

endmodule

// File: rtl/spm_scratchpad_chk.sv
module spm_scratchpad_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_we,
    input logic [1:0]        acc_size,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] acc_rdata
);
    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] s);
        case (s)
            2'd0:    return {{(DATA_W-8){1'b0}}, 8'hFF};
            2'd1:    return {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: return '1;
        endcase
    endfunction

    // R8: no read request, no change on the read port
    p_hold_when_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_we) |=> $stable(acc_rdata));

    // R7: byte reads are zero-extended
    p_byte_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && acc_size == 2'd0) |=> (acc_rdata[DATA_W-1:8] == '0));

    // R7: halfword reads are zero-extended
    p_half_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && acc_size == 2'd1) |=> (acc_rdata[DATA_W-1:16] == '0));

    // R9: write then immediate read of same size and address returns the write
    p_write_read_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we && $past(acc_en && acc_we) &&
         acc_addr == $past(acc_addr) && acc_size == $past(acc_size))
        |=> (acc_rdata == ($past(acc_wdata, 2) & size_mask($past(acc_size)))));

endmodule

bind spm_scratchpad spm_scratchpad_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_size  (acc_size),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata)
);

// File: tb/spm_scratchpad_test.sv
module spm_scratchpad_test;

    localparam int MEM_BYTES = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [1:0]  acc_size = 2'd0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0]  model_mem [MEM_BYTES];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;   // 250 MHz

    spm_scratchpad uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_size  (acc_size),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    function automatic int nb(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] model_read(input logic [1:0] s, input logic [11:0] a);
        logic [31:0] r = '0;
        for (int k = 0; k < nb(s); k++) begin
            r = (r << 8) | 32'(model_mem[(int'(a) + k) % MEM_BYTES]);
        end
        return r;
    endfunction

    task automatic model_write(input logic [1:0] s, input logic [11:0] a, input logic [31:0] d);
        for (int k = 0; k < nb(s); k++) begin
            model_mem[(int'(a) + k) % MEM_BYTES] = 8'(d >> (8 * (nb(s) - 1 - k)));
        end
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // one-cycle write; signals are left for the next operation to overwrite
    task automatic op_write(input logic [1:0] s, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_size = s; acc_addr = a; acc_wdata = d;
        model_write(s, a, d);
    endtask

    task automatic op_idle();
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    // read request, then an idle cycle; result checked one edge later
    task automatic op_read(input logic [1:0] s, input logic [11:0] a, input string req);
        logic [31:0] exp;
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_size = s; acc_addr = a;
        exp = model_read(s, a);
        @(negedge clk);
        acc_en = 1'b0;
        check(req, acc_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        logic [31:0] expv;
        logic [11:0] a;
        logic [1:0]  s;

        for (int i = 0; i < MEM_BYTES; i++) model_mem[i] = 8'h00;

        repeat (3) @(negedge clk);
        check("R10 reset value", acc_rdata, 32'h0);
        rst_n = 1'b1;

        // R1 / R5: fill every byte with a distinct pattern
        for (int i = 0; i < MEM_BYTES; i++) begin
            op_write(2'd0, 12'(i), 32'hFFFFFF00 | 32'((i * 29 + (i >> 8)) & 8'hFF));
        end
        op_idle();
        for (int i = 0; i < MEM_BYTES; i++) op_read(2'd0, 12'(i), "R1 byte sweep");

        // R2 / R4: halfword at every start address, including 0xFFF
        for (int i = 0; i < MEM_BYTES; i++) op_read(2'd1, 12'(i), "R2 half sweep");

        // R3 / R4: word at every start address, including 0xFFD..0xFFF
        for (int i = 0; i < MEM_BYTES; i++) op_read(2'd2, 12'(i), "R3 word sweep");

        // R4 / R5: explicit wrapping word write, bytes read one by one
        op_write(2'd2, 12'hFFE, 32'hA1B2C3D4);
        op_idle();
        op_read(2'd0, 12'hFFE, "R4 wrap byte FFE");
        check("R4 wrap FFE value", acc_rdata, 32'hA1);
        op_read(2'd0, 12'hFFF, "R4 wrap byte FFF");
        check("R4 wrap FFF value", acc_rdata, 32'hB2);
        op_read(2'd0, 12'h000, "R4 wrap byte 000");
        check("R4 wrap 000 value", acc_rdata, 32'hC3);
        op_read(2'd0, 12'h001, "R4 wrap byte 001");
        check("R4 wrap 001 value", acc_rdata, 32'hD4);
        op_read(2'd0, 12'h002, "R5 byte after wrap untouched");

        // R4: wrapping halfword write at 0xFFF
        op_write(2'd1, 12'hFFF, 32'h12345E6F);
        op_idle();
        op_read(2'd2, 12'hFFE, "R4 half wrap seen as word");
        check("R4 half wrap value", acc_rdata, 32'hA15E6FD4);

        // R7: code 3 behaves as word
        op_write(2'd3, 12'h123, 32'hCAFEF00D);
        op_idle();
        op_read(2'd2, 12'h123, "R7 size3 write");
        op_read(2'd3, 12'h123, "R7 size3 read");
        check("R7 size3 value", acc_rdata, 32'hCAFEF00D);

        // R5 / R9: random misaligned writes, each read back in the next cycle
        for (int i = 0; i < 600; i++) begin
            step_lfsr();
            a = lfsr[11:0];
            s = lfsr[13:12];
            step_lfsr();
            expv = {lfsr, lfsr ^ 16'h5A5A};
            op_write(s, a, expv);
            op_read(s, a, "R9 write-then-read");
            op_read(2'd2, a - 12'd2, "R5 neighbours below");
            op_read(2'd2, a + 12'(nb(s)), "R5 neighbours above");
        end

        // R6: back-to-back reads, each checked one cycle after its request
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (i > 0) check("R6 pipelined read", acc_rdata, held);
            acc_en = 1'b1; acc_we = 1'b0;
            acc_size = 2'(i % 3);
            acc_addr = 12'(4093 + i * 37);
            held = model_read(acc_size, acc_addr);
        end
        @(negedge clk);
        acc_en = 1'b0;
        check("R6 pipelined read last", acc_rdata, held);

        // R8: hold through idle cycles and through a write to the same address
        op_read(2'd2, 12'h0F0, "R8 setup read");
        held = acc_rdata;
        op_idle();
        op_idle();
        check("R8 hold idle", acc_rdata, held);
        op_write(2'd2, 12'h0F0, ~held);
        op_idle();
        check("R8 hold across write", acc_rdata, held);
        op_read(2'd2, 12'h0F0, "R8 new data visible on read");

        // R10: reset clears read data but keeps contents
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset clears rdata", acc_rdata, 32'h0);
        rst_n = 1'b1;
        op_read(2'd2, 12'h0F0, "R10 contents survive reset");
        op_read(2'd2, 12'hFFE, "R10 wrap contents survive reset");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule